// File: doc/BRIEF.md
# Endian-Aware Bus Sizing Adapter

This block connects an internal 32-bit bus-master request port to an external data bus that may be 32 or 16 bits wide. The master hands over one word request: address, write data and direction. The adapter runs one external cycle when the bus reports full width. When the bus reports half width, it runs two back-to-back cycles. The bus width is read from an input at the moment the first external cycle is acknowledged, so the choice is made again for every transfer.

On a 16-bit bus the byte-order input decides two things: which lanes carry the half-word, and which half goes first. In little-endian order the half-words use lines 15..0, and the low half is sent first. In big-endian order they use lines 31..16, and the high half is sent first. On reads, the first half-word is held in a register until the second one arrives. The master then sees a single completion pulse together with the reassembled word. The same ordering applies to every transfer, whether it carries frame data or control structures.

Top module: `bus_size_adapter`

## Requirements
- R1: After reset, `req_ready` is 1, `ext_cyc` is 0 and `rsp_valid` is 0.
- R2: If `bus_wide` is 1 when the first external cycle is acknowledged, the transfer takes one cycle at the request address. A write drives all 32 bits of `ext_wdata` unchanged. A read returns `ext_rdata` unchanged in `rsp_rdata`.
- R3: If `bus_wide` is 0 at that acknowledge, a second external cycle follows on the next clock at the request address plus 2.
- R4: Little-endian (`byte_le`=1) narrow write: the first cycle carries `wdata[15:0]` and the second carries `wdata[31:16]`, both on lines 15..0. Lines 31..16 are 0.
- R5: Big-endian (`byte_le`=0) narrow write: the first cycle carries `wdata[31:16]` and the second carries `wdata[15:0]`, both on lines 31..16. Lines 15..0 are 0.
- R6: Little-endian narrow read: `rsp_rdata` = {second cycle lines 15..0, first cycle lines 15..0}. Lines 31..16 are ignored.
- R7: Big-endian narrow read: `rsp_rdata` = {first cycle lines 31..16, second cycle lines 31..16}. Lines 15..0 are ignored.
- R8: `rsp_valid` is a single one-cycle pulse. It rises in the clock after the last acknowledged external cycle, and never after the first half of a split transfer.
- R9: While `ext_ready` is 0, the external cycle is held, with `ext_addr` and `ext_we` unchanged.
- R10: During the second half of a split transfer, `bus_wide` has no effect on the address or the data lanes.
- R11: A request is accepted only while `req_ready` is 1, which is never during an external cycle. `byte_le` is captured at acceptance, and later changes do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Word request present |
| req_ready | output | 1 | Adapter idle, request accepted |
| req_addr | input | ADDR_W | Word base address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 32 | Reassembled read word |
| bus_wide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| byte_le | input | 1 | 1 = little-endian, 0 = big-endian |
| ext_cyc | output | 1 | External cycle active |
| ext_addr | output | ADDR_W | External cycle address |
| ext_we | output | 1 | External cycle is a write |
| ext_wdata | output | 32 | External write lanes |
| ext_rdata | input | 32 | External read lanes |
| ext_ready | input | 1 | External cycle acknowledge |

## Verification
The assertions assume three things about the environment:
- `ext_ready` is only meaningful while `ext_cyc` is high.
- The request address is word aligned, so adding 2 never carries into a neighbouring word.
- `bus_wide` is settled at each first-cycle acknowledge.

The stimulus drives every input on the falling edge and raises `ext_ready` only inside an active cycle. To exercise R10 and R11, it deliberately flips `bus_wide` and `byte_le` during the second half of split transfers. Wait states of zero to three cycles are inserted on every beat.

// File: rtl/bus_size_adapter.sv
module bus_size_adapter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              bus_wide,
  input  logic              byte_le,
  output logic              ext_cyc,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_we,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  input  logic              ext_ready
);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [31:0]       wd_q;
  logic              le_q;
  logic [15:0]       hold_q;
  logic [15:0]       half_out;
  logic [15:0]       lane_in;
  logic [31:0]       lane_out;

  assign req_ready = (st == ST_IDLE);
  assign ext_cyc   = (st != ST_IDLE);
  assign ext_we    = ext_cyc && we_q;
  assign ext_addr  = (st == ST_SECOND) ? addr_q + ADDR_W'(2) : addr_q;

  assign half_out  = ((st == ST_FIRST) == le_q) ? wd_q[15:0] : wd_q[31:16];
  assign lane_out  = le_q ? {16'h0, half_out} : {half_out, 16'h0};
  assign lane_in   = le_q ? ext_rdata[15:0] : ext_rdata[31:16];

  assign ext_wdata = !ext_cyc ? 32'h0 :
                     (st == ST_FIRST && bus_wide) ? wd_q : lane_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      le_q      <= 1'b1;
      hold_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          we_q   <= req_we;
          wd_q   <= req_wdata;
          le_q   <= byte_le;
          st     <= ST_FIRST;
        end
        ST_FIRST: if (ext_ready) begin
          if (bus_wide) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= ext_rdata;
            st        <= ST_IDLE;
          end else begin
            hold_q <= lane_in;
            st     <= ST_SECOND;
          end
        end
        ST_SECOND: if (ext_ready) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= le_q ? {lane_in, hold_q} : {hold_q, lane_in};
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SECOND_FROM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND && $past(st) != ST_SECOND) |-> $past(st == ST_FIRST && ext_ready && !bus_wide)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND && $past(st) == ST_FIRST) |-> ext_addr == $past(ext_addr) + ADDR_W'(2)); // R3
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cyc && !ext_ready) |=> (ext_cyc && $stable(ext_addr) && $stable(ext_we))); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ext_cyc && ext_ready)); // R8
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc |-> !req_ready); // R11
  AST_NARROW_LANE_LE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND && ext_we && le_q) |-> ext_wdata[31:16] == 16'h0); // R4
  AST_NARROW_LANE_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND && ext_we && !le_q) |-> ext_wdata[15:0] == 16'h0); // R5

endmodule

// File: tb/bus_size_adapter_tb_top.sv
module bus_size_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_wide = 1'b1;
  logic        byte_le = 1'b1;
  logic        ext_cyc;
  logic [31:0] ext_addr;
  logic        ext_we;
  logic [31:0] ext_wdata;
  logic [31:0] ext_rdata = '0;
  logic        ext_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_size_adapter #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_wide(bus_wide),
    .byte_le(byte_le), .ext_cyc(ext_cyc), .ext_addr(ext_addr), .ext_we(ext_we),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                      input bit wide, input bit le, input int waits);
    logic [15:0] h [2];
    logic [31:0] full;
    logic [31:0] exp_w;
    logic [31:0] exp_r;
    int nb;
    h[0] = $urandom; h[1] = $urandom; full = $urandom;
    nb = wide ? 1 : 2;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_we = we; req_wdata = wd;
    bus_wide = wide; byte_le = le;
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      if (b == 1) begin
        bus_wide = 1'b1;
        byte_le = ~le;
      end
      if (wide) exp_w = wd;
      else if (le) exp_w = {16'h0, (b == 0) ? wd[15:0] : wd[31:16]};
      else exp_w = {(b == 0) ? wd[31:16] : wd[15:0], 16'h0};
      for (int w = 0; w <= waits; w++) begin
        check(ext_cyc === 1'b1, "R9 cycle held", {31'h0, ext_cyc}, 32'h1);
        check(req_ready === 1'b0, "R11 busy not ready", {31'h0, req_ready}, 32'h0);
        check(ext_addr === addr + ((b == 1) ? 32'd2 : 32'd0), b == 1 ? "R3 second address" : "R2 base address", ext_addr, addr + ((b == 1) ? 32'd2 : 32'd0));
        check(ext_we === we, "R9 direction", {31'h0, ext_we}, {31'h0, we});
        check(rsp_valid === 1'b0, "R8 no early response", {31'h0, rsp_valid}, 32'h0);
        if (we) check(ext_wdata === exp_w, wide ? "R2 wide lanes" : (b == 1 ? "R10 second half lanes" : (le ? "R4 le lanes" : "R5 be lanes")), ext_wdata, exp_w);
        ext_ready = (w == waits);
        if (wide) ext_rdata = full;
        else if (le) ext_rdata = {16'hDEAD, h[b]};
        else ext_rdata = {h[b], 16'hBEEF};
        @(negedge clk);
      end
    end
    ext_ready = 1'b0;
    ext_rdata = 32'h0;
    if (wide) exp_r = full;
    else if (le) exp_r = {h[1], h[0]};
    else exp_r = {h[0], h[1]};
    check(rsp_valid === 1'b1, "R8 response pulse", {31'h0, rsp_valid}, 32'h1);
    check(ext_cyc === 1'b0, "R3 cycle count", {31'h0, ext_cyc}, 32'h0);
    if (!we) check(rsp_rdata === exp_r, wide ? "R2 wide read" : (le ? "R6 le read" : "R7 be read"), rsp_rdata, exp_r);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R8 single pulse", {31'h0, rsp_valid}, 32'h0);
    check(req_ready === 1'b1, "R11 ready again", {31'h0, req_ready}, 32'h1);
  endtask

  task automatic test_reset();
    check(req_ready === 1'b1, "R1 ready", {31'h0, req_ready}, 32'h1);
    check(ext_cyc === 1'b0, "R1 idle bus", {31'h0, ext_cyc}, 32'h0);
    check(rsp_valid === 1'b0, "R1 no response", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic test_wide();
    xfer(32'h0000_1000, 1'b1, 32'hCAFE_F00D, 1'b1, 1'b1, 0);
    xfer(32'h0000_1004, 1'b0, 32'h0, 1'b1, 1'b0, 2);
  endtask

  task automatic test_narrow_le();
    xfer(32'h0000_2000, 1'b1, 32'h1234_5678, 1'b0, 1'b1, 0);
    xfer(32'h0000_2008, 1'b0, 32'h0, 1'b0, 1'b1, 3);
  endtask

  task automatic test_narrow_be();
    xfer(32'h0000_3000, 1'b1, 32'hA1B2_C3D4, 1'b0, 1'b0, 1);
    xfer(32'h0000_300C, 1'b0, 32'h0, 1'b0, 1'b0, 0);
  endtask

  task automatic test_mixed();
    for (int i = 0; i < 12; i++)
      xfer({$urandom} & 32'hFFFF_FFF0, i[0], $urandom, i[1], i[2], i % 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_wide();
    test_narrow_le();
    test_narrow_be();
    test_mixed();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule